// File: doc/BRIEF.md
# Station Address PROM Sync and Checksum Checker

This block reads a station address PROM that sits behind a single byte port, where every read returns the next byte of the device. After a start pulse it first looks for an eight-byte synchronisation marker in the byte stream. It then captures a six-byte hardware address followed by a two-byte stored checksum, and reports whether the address is usable.

The address is usable when three conditions hold. The stored checksum must equal a running shift-and-fold sum over the three little-endian address words, the address must not be a group (multicast) address, and its first three bytes must not all be zero. An option skips the marker search for devices that start directly with the address.

Reads use a request/valid handshake, so a slow PROM can stall the block for any number of cycles. A one-cycle done pulse ends every run, and an error flag is valid in that same cycle.

Top module: `srom_addr_check`

## Requirements
- R1: With the skip option low, the block searches for the marker FF 00 55 AA FF 00 55 AA in at most HUNT_LIMIT (default 32) byte reads. A marker completed on the last allowed read is accepted. If the marker is not complete after HUNT_LIMIT reads, the run ends with done and error and makes no further reads.
- R2: During the search, a byte that does not match the expected marker byte sends the match position back to the first marker byte. That same byte is not compared again against the first marker byte.
- R3: With the skip option high when start is accepted, the first byte read is address byte 0.
- R4: The sum starts as word 0 = byte0 + 256*byte1. For each later word (bytes 2,3 then bytes 4,5), the sum is doubled, 65535 is subtracted if the result is above 65535, the word is added, and the result is folded the same way. The two bytes after the address are the stored checksum, low byte first. If they differ from the sum, the run ends in error.
- R5: The fold after the third word subtracts 65535 when the sum is greater than or equal to 65535, so a sum of exactly 65535 becomes 0.
- R6: An address whose byte 0 has bit 0 set ends in error, even when the checksum matches.
- R7: An address whose bytes 0, 1 and 2 are all zero ends in error, even when the checksum matches.
- R8: done is high for exactly one cycle, in the cycle after the final byte is taken. error is high only in a done cycle, and is high there exactly when the run failed.
- R9: mac_addr holds address byte i in bits [8i+7:8i]. It is cleared in the cycle after start is accepted, loads each byte in the cycle after that byte is taken, and holds its value otherwise, including after done, until the next accepted start.
- R10: A byte is taken only on a rising clock edge where rd_req and rd_valid are both high. rd_req rises in the cycle after start is accepted and falls in the cycle after the final byte is taken. A start that arrives while a run is in progress is ignored.
- R11: While reset is high, rd_req, done and error are low and mac_addr is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a run when the block is idle |
| skip_sync | input | 1 | Skip the marker search for this run |
| rd_req | output | 1 | Block wants the next PROM byte |
| rd_valid | input | 1 | rd_data holds the next PROM byte |
| rd_data | input | 8 | PROM byte |
| mac_addr | output | 48 | Captured address, byte 0 in the low bits |
| done | output | 1 | One-cycle end-of-run pulse |
| error | output | 1 | Run failed; valid with done |

## Verification
The bench instantiates the block with its default parameters: a 32-read search window, an eight-byte marker and a six-byte address. With these values the window edge can be reached exactly, both with a marker that completes on read 32 and with one that would complete on read 33. They also allow a stream that only a search with overlap recovery would lock onto. The stored checksums are chosen so that the middle fold and the final greater-or-equal fold both fire, and the PROM model stalls every third cycle in some runs.

// File: rtl/srom_pkg.sv
package srom_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HUNT = 2'd1,
    ST_ADDR = 2'd2,
    ST_CSUM = 2'd3
  } srom_state_e;

  // marker repeats a four-byte motif
  function automatic logic [7:0] sync_byte(input int unsigned pos);
    case (pos % 4)
      0:       sync_byte = 8'hFF;
      1:       sync_byte = 8'h00;
      2:       sync_byte = 8'h55;
      default: sync_byte = 8'hAA;
    endcase
  endfunction

endpackage

// File: rtl/srom_sync_hunt.sv
module srom_sync_hunt #(
  parameter int SYNC_LEN   = 8,
  parameter int HUNT_LIMIT = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       take,
  input  logic [7:0] din,
  output logic       found,
  output logic       give_up
);
  localparam int POS_W = $clog2(SYNC_LEN + 1);
  localparam int CNT_W = $clog2(HUNT_LIMIT + 1);

  logic [POS_W-1:0] pos_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       want;
  logic             hit;

  always_comb begin
    want    = srom_pkg::sync_byte(32'(pos_q));
    hit     = (din == want);
    found   = take && hit && (pos_q == POS_W'(SYNC_LEN - 1));
    give_up = take && !found && (cnt_q == CNT_W'(HUNT_LIMIT - 1));
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pos_q <= '0;
      cnt_q <= '0;
    end else if (take) begin
      cnt_q <= cnt_q + 1'b1;
      // mismatch restarts without rechecking this byte
      pos_q <= hit ? pos_q + 1'b1 : '0;
    end
  end

endmodule

// File: rtl/srom_fold_sum.sv
module srom_fold_sum #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              first,
  input  logic              last,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] sum
);
  localparam int EXT_W = WORD_W + 2;
  localparam logic [EXT_W-1:0] MODV = EXT_W'((64'd1 << WORD_W) - 64'd1);

  logic [WORD_W-1:0] acc_q;
  logic [EXT_W-1:0]  dbl, dbl_f, add, add_f;

  always_comb begin
    dbl   = {1'b0, acc_q, 1'b0};
    dbl_f = (dbl > MODV) ? dbl - MODV : dbl;
    add   = dbl_f + {2'b00, word};
    if (last) add_f = (add >= MODV) ? add - MODV : add;
    else      add_f = (add >  MODV) ? add - MODV : add;
  end

  always_ff @(posedge clk) begin
    if (rst)       acc_q <= '0;
    else if (load) acc_q <= first ? word : add_f[WORD_W-1:0];
  end

  assign sum = acc_q;

endmodule

// File: rtl/srom_addr_check.sv
module srom_addr_check
  import srom_pkg::*;
#(
  parameter int HUNT_LIMIT = 32,
  parameter int SYNC_LEN   = 8,
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic                    skip_sync,
  output logic                    rd_req,
  input  logic                    rd_valid,
  input  logic [7:0]              rd_data,
  output logic [8*ADDR_BYTES-1:0] mac_addr,
  output logic                    done,
  output logic                    error
);
  localparam int IDX_W  = $clog2(ADDR_BYTES + 1);
  localparam int WORD_W = 16;

  srom_state_e      state_q, state_d;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       hold_q;
  logic             csum_hi_q;
  logic             rd_req_q, done_q, error_q;
  logic [7:0]       lane_q [ADDR_BYTES];

  logic take, accept, hunt_take, addr_take, csum_take;
  logic sync_found, sync_gave_up;
  logic fin, fin_err, addr_bad;
  logic [WORD_W-1:0] fold_sum;

  assign take      = rd_req_q && rd_valid;
  assign accept    = (state_q == ST_IDLE) && start;
  assign hunt_take = take && (state_q == ST_HUNT);
  assign addr_take = take && (state_q == ST_ADDR);
  assign csum_take = take && (state_q == ST_CSUM);

  srom_sync_hunt #(
    .SYNC_LEN  (SYNC_LEN),
    .HUNT_LIMIT(HUNT_LIMIT)
  ) u_hunt (
    .clk    (clk),
    .rst    (rst),
    .clr    (accept),
    .take   (hunt_take),
    .din    (rd_data),
    .found  (sync_found),
    .give_up(sync_gave_up)
  );

  srom_fold_sum #(
    .WORD_W(WORD_W)
  ) u_fold (
    .clk  (clk),
    .rst  (rst),
    .load (addr_take && idx_q[0]),
    .first(idx_q == IDX_W'(1)),
    .last (idx_q == IDX_W'(ADDR_BYTES - 1)),
    .word ({rd_data, hold_q}),
    .sum  (fold_sum)
  );

  genvar g;
  generate
    for (g = 0; g < ADDR_BYTES; g++) begin : g_lane
      always_ff @(posedge clk) begin
        if (rst || accept)                           lane_q[g] <= '0;
        else if (addr_take && idx_q == IDX_W'(g))    lane_q[g] <= rd_data;
      end
      assign mac_addr[8*g +: 8] = lane_q[g];
    end
  endgenerate

  always_comb begin
    addr_bad = ({rd_data, hold_q} != fold_sum) || lane_q[0][0] ||
               (mac_addr[23:0] == 24'd0);
  end

  always_comb begin
    state_d = state_q;
    fin     = 1'b0;
    fin_err = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) state_d = skip_sync ? ST_ADDR : ST_HUNT;
      ST_HUNT: begin
        if (sync_found) begin
          state_d = ST_ADDR;
        end else if (sync_gave_up) begin
          state_d = ST_IDLE;
          fin     = 1'b1;
          fin_err = 1'b1;
        end
      end
      ST_ADDR: if (addr_take && idx_q == IDX_W'(ADDR_BYTES - 1)) state_d = ST_CSUM;
      ST_CSUM: begin
        if (csum_take && csum_hi_q) begin
          state_d = ST_IDLE;
          fin     = 1'b1;
          fin_err = addr_bad;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      hold_q    <= '0;
      csum_hi_q <= 1'b0;
      rd_req_q  <= 1'b0;
      done_q    <= 1'b0;
      error_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      rd_req_q <= (state_d != ST_IDLE);
      done_q   <= fin;
      error_q  <= fin_err;
      if (take) hold_q <= rd_data;
      if (accept) begin
        idx_q     <= '0;
        csum_hi_q <= 1'b0;
      end else begin
        if (addr_take) idx_q <= idx_q + 1'b1;
        if (csum_take) csum_hi_q <= 1'b1;
      end
    end
  end

  assign rd_req = rd_req_q;
  assign done   = done_q;
  assign error  = error_q;

endmodule

// File: rtl/srom_addr_check_chk.sv
module srom_addr_check_chk #(
  parameter int HUNT_LIMIT = 32,
  parameter int SYNC_LEN   = 8,
  parameter int ADDR_BYTES = 6
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    start,
  input logic                    rd_req,
  input logic                    rd_valid,
  input logic [8*ADDR_BYTES-1:0] mac_addr,
  input logic                    done,
  input logic                    error
);
  localparam int MAX_READS = HUNT_LIMIT + ADDR_BYTES + 2;

  int unsigned rd_cnt;

  always_ff @(posedge clk) begin
    if (rst || done)             rd_cnt <= 0;
    else if (rd_req && rd_valid) rd_cnt <= rd_cnt + 1;
  end

  AST_READ_BOUND: assert property (@(posedge clk) disable iff (rst)
    rd_cnt <= MAX_READS); // R1
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    error |-> done); // R8
  AST_NO_REQ_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> !rd_req); // R10
  AST_REQ_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_req) |-> $past(start)); // R10
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!start && !(rd_req && rd_valid)) |=> $stable(mac_addr)); // R9
  AST_GOOD_NOT_GROUP: assert property (@(posedge clk) disable iff (rst)
    (done && !error) |-> !mac_addr[0]); // R6
  AST_GOOD_OUI: assert property (@(posedge clk) disable iff (rst)
    (done && !error) |-> (mac_addr[23:0] != 24'd0)); // R7

endmodule

bind srom_addr_check srom_addr_check_chk #(
  .HUNT_LIMIT(HUNT_LIMIT),
  .SYNC_LEN  (SYNC_LEN),
  .ADDR_BYTES(ADDR_BYTES)
) u_chk (.*);

// File: tb/srom_addr_check_bench.sv
module srom_addr_check_bench;
  logic        clk = 1'b0, rst = 1'b1, start = 1'b0, skip_sync = 1'b0;
  logic        rd_valid = 1'b0;
  logic [7:0]  rd_data = 8'h00;
  logic        rd_req, done, error;
  logic [47:0] mac_addr;

  always #10 clk = ~clk;

  srom_addr_check u_srom_addr_check (
    .clk(clk), .rst(rst), .start(start), .skip_sync(skip_sync),
    .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
    .mac_addr(mac_addr), .done(done), .error(error)
  );

  logic [7:0] rom [0:63];
  logic [7:0] ab  [0:5];
  int idx = 0, stall_mode = 0, stall_ctr = 0, wd = 0;
  int checks = 0, fails = 0;
  string cur_req = "R4";

  logic s_start = 0, s_skip = 0, s_took = 0;
  logic [7:0] s_data = 0;
  always @(posedge clk) begin
    s_start <= start;
    s_skip  <= skip_sync;
    s_took  <= rd_req & rd_valid;
    s_data  <= rd_data;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int fold_sum(input int w0, input int w1, input int w2);
    int s;
    s = w0;
    s = s * 2; if (s > 65535) s -= 65535;
    s = s + w1; if (s > 65535) s -= 65535;
    s = s * 2; if (s > 65535) s -= 65535;
    s = s + w2; if (s >= 65535) s -= 65535;
    return s;
  endfunction

  // reference model state
  int m_st = 0, m_pos = 0, m_cnt = 0, m_bi = 0, m_ci = 0;
  logic [7:0] m_lo = 0;
  logic [7:0] m_addr [0:5] = '{default: 8'h00};
  logic e_done, e_err;

  function automatic logic [47:0] m_pack();
    logic [47:0] v;
    for (int i = 0; i < 6; i++) v[8*i +: 8] = m_addr[i];
    return v;
  endfunction

  task automatic m_byte(input logic [7:0] b);
    logic [7:0] pat [0:3];
    int s;
    pat = '{8'hFF, 8'h00, 8'h55, 8'hAA};
    if (m_st == 1) begin
      m_cnt++;
      if (b == pat[m_pos % 4]) begin
        m_pos++;
        if (m_pos == 8) begin m_st = 2; m_bi = 0; end
      end else m_pos = 0;
      if (m_st == 1 && m_cnt == 32) begin m_st = 0; e_done = 1; e_err = 1; end
    end else if (m_st == 2) begin
      m_addr[m_bi] = b;
      m_bi++;
      if (m_bi == 6) begin m_st = 3; m_ci = 0; end
    end else if (m_st == 3) begin
      if (m_ci == 0) begin m_lo = b; m_ci = 1; end
      else begin
        s = fold_sum({m_addr[1], m_addr[0]}, {m_addr[3], m_addr[2]},
                     {m_addr[5], m_addr[4]});
        e_done = 1;
        e_err  = (s != {b, m_lo}) || m_addr[0][0] ||
                 (m_addr[0] == 0 && m_addr[1] == 0 && m_addr[2] == 0);
        m_st = 0;
      end
    end
  endtask

  always @(negedge clk) begin
    wd++;
    if (wd > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <150000", wd);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
    if (rst) begin
      m_st = 0;
      for (int i = 0; i < 6; i++) m_addr[i] = 0;
    end else begin
      e_done = 0; e_err = 0;
      if (m_st == 0 && s_start) begin
        m_st = s_skip ? 2 : 1;
        m_pos = 0; m_cnt = 0; m_bi = 0;
        for (int i = 0; i < 6; i++) m_addr[i] = 0;
      end else if (s_took) begin
        m_byte(s_data);
      end
      chk(rd_req === (m_st != 0), "R10", "rd_req", rd_req, m_st != 0);
      chk(done === e_done, "R8", "done", done, e_done);
      chk(error === e_err, cur_req, "error", error, e_err);
      chk(mac_addr === m_pack(), "R9", "mac_addr", mac_addr, m_pack());
    end
    if (s_took) idx++;
    stall_ctr++;
    rd_valid = (stall_mode == 0) ? 1'b1 : ((stall_ctr % 3) != 0);
    rd_data  = rom[idx & 63];
  end

  task automatic clear_rom();
    for (int i = 0; i < 64; i++) rom[i] = 8'h00;
  endtask

  task automatic set_ab(input logic [7:0] b0, b1, b2, b3, b4, b5);
    ab[0] = b0; ab[1] = b1; ab[2] = b2; ab[3] = b3; ab[4] = b4; ab[5] = b5;
  endtask

  task automatic put_sync(input int base);
    logic [7:0] pat [0:3];
    pat = '{8'hFF, 8'h00, 8'h55, 8'hAA};
    for (int i = 0; i < 8; i++) rom[base + i] = pat[i % 4];
  endtask

  task automatic put_addr(input int base, input bit corrupt);
    int s;
    for (int i = 0; i < 6; i++) rom[base + i] = ab[i];
    s = fold_sum({ab[1], ab[0]}, {ab[3], ab[2]}, {ab[5], ab[4]});
    if (corrupt) s = s ^ 1;
    rom[base + 6] = s[7:0];
    rom[base + 7] = s[15:8];
  endtask

  task automatic run(input bit skip, input int stall, input bit exp_err,
                     input string req, input int exp_reads, input bit poke);
    int t;
    @(negedge clk);
    cur_req = req; skip_sync = skip; stall_mode = stall; idx = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(mac_addr == 48'd0, "R9", "cleared after start", mac_addr, 0);
    if (poke) begin
      repeat (5) @(negedge clk);
      start = 1'b1;             // R10: ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    chk(done == 1'b1, req, "done seen", done, 1);
    chk(error == exp_err, req, "final error", error, exp_err);
    @(negedge clk);
    chk(idx == exp_reads, req, "bytes read", idx, exp_reads);
    chk(done == 1'b0, "R8", "done one cycle", done, 0);
  endtask

  initial begin
    clear_rom();
    repeat (3) @(negedge clk);
    chk(rd_req == 0 && done == 0 && error == 0, "R11", "reset outputs",
        {rd_req, done, error}, 0);
    chk(mac_addr == 48'd0, "R11", "reset address", mac_addr, 0);
    rst = 1'b0;

    // R1/R4: marker after junk, stalls, restart attempt mid-run (R10)
    clear_rom(); rom[0] = 8'h12; rom[1] = 8'h34; rom[2] = 8'h56;
    put_sync(3); set_ab(8'h08, 8'h00, 8'h2B, 8'h11, 8'h22, 8'h33); put_addr(11, 0);
    run(0, 1, 0, "R1", 19, 1);
    repeat (4) @(negedge clk);
    chk(mac_addr == 48'h33_22_11_2B_00_08, "R9", "address held", mac_addr,
        48'h33_22_11_2B_00_08);
    // R4: stored checksum off by one
    put_addr(11, 1);
    run(0, 1, 1, "R4", 19, 0);
    // R3: skip option, middle fold fires
    clear_rom(); set_ab(8'h00, 8'h80, 8'hC0, 8'hFF, 8'hEE, 8'h12); put_addr(0, 0);
    run(1, 0, 0, "R3", 8, 0);
    // R5: sum lands exactly on 65535 before the last fold
    clear_rom(); set_ab(8'h02, 8'h00, 8'h00, 8'h00, 8'hF7, 8'hFF); put_addr(0, 0);
    chk(rom[6] == 8'h00 && rom[7] == 8'h00, "R5", "fold to zero",
        {rom[7], rom[6]}, 0);
    run(1, 1, 0, "R5", 8, 0);
    rom[6] = 8'hFF; rom[7] = 8'hFF;
    run(1, 0, 1, "R5", 8, 0);
    // R6: group address with matching checksum
    clear_rom(); put_sync(0); set_ab(8'h09, 8'h00, 8'h2B, 8'h01, 8'h02, 8'h03);
    put_addr(8, 0);
    run(0, 0, 1, "R6", 16, 0);
    // R7: zero first three bytes with matching checksum
    clear_rom(); put_sync(0); set_ab(8'h00, 8'h00, 8'h00, 8'h12, 8'h34, 8'h56);
    put_addr(8, 0);
    run(0, 1, 1, "R7", 16, 0);
    // R1: no marker at all
    clear_rom();
    run(0, 0, 1, "R1", 32, 0);
    // R2: marker only reachable with overlap recovery
    clear_rom();
    rom[0] = 8'hFF; rom[1] = 8'h00; rom[2] = 8'h55; put_sync(3);
    run(0, 1, 1, "R2", 32, 0);
    // R1: marker finishing on read 32, then on read 33
    clear_rom(); put_sync(24); set_ab(8'h08, 8'h00, 8'h2B, 8'hA1, 8'hB2, 8'hC3);
    put_addr(32, 0);
    run(0, 0, 0, "R1", 40, 0);
    clear_rom(); put_sync(25); put_addr(33, 0);
    run(0, 0, 1, "R1", 32, 0);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule